// File: doc/BRIEF.md
# Per-Channel Interrupt Status Controller

This block turns the real-time condition lines of a multi-channel line interface into latched interrupt events and one shared interrupt pin. Each channel carries sixteen condition lines, split into two 8-bit groups. Examples of these conditions are equalizer state, loopback-code detection in either direction, pseudo-random pattern sync, transmit clock loss, driver fault, alarm signal, signal loss, jitter buffer overflow and underflow, error counter saturation, excess zeros and code violations. For every line, software selects whether a rising level alone or any level change latches an event. It also selects whether the latched event reaches the pin.

Software reaches the block through a single-cycle register port. A read clears the latched group it returns. A global register shows which channels hold an unmasked event, and a second global register selects how the pin is driven. The block does not produce the condition lines. The register port is a plain control port with no valid/ready handshake: the block accepts every access, and read data appears the cycle after the read strobe.

Address layout (6 bits with default parameters): bit 0 selects the group (low or high eight lines). Bits 2:1 select the register kind: 0 is mask, 1 is edge select, 2 is live level, 3 is latched status. Bit 3 set selects the global space, where kind 0 is the pin mode and kind 1 is the channel indication. Bits 5:4 select the channel, and the global space ignores them. Condition line `s` of channel `c` is `cond_live[c*16+s]`, and group `g` holds lines `8g` to `8g+7`.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every edge-select bit reads 0, the pin mode reads 0, and the pin is not driven.
- R2: With edge select 0, a 0-to-1 change of a line sets its latched status bit on the clock edge that first samples the new level. A 1-to-0 change sets nothing.
- R3: With edge select 1, both a 0-to-1 and a 1-to-0 change of a line set its latched status bit.
- R4: A read of a latched status group returns the latched bits on `rd_data` in the cycle after `rd_en`, and the same edge clears that group.
- R5: An event that arrives on the same clock edge as the read of its group is kept latched. That read returns the value from before the edge.
- R6: The live-level register returns the current level of each line, whatever the latched status holds.
- R7: The interrupt is active exactly when some latched status bit with a mask bit of 0 is set in any channel. Masked events still latch and can be read.
- R8: Pin mode (global kind 0, bits 1:0): with bit 0 clear, the pin is open drain active low (`irq_oe` equals active, and `irq_level` is 0). Mode 01 drives the pin at all times, active low. Mode 11 drives the pin at all times, active high.
- R9: Bit `c` of the channel indication register (global kind 1) is 1 exactly when channel `c` holds an unmasked latched event.
- R10: Writes to live, latched and indication registers have no effect. Mask and edge registers read back what was written. `rd_data` holds its value when no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_live | input | NUM_CH*DATA_W*GROUPS | Real-time condition lines, 16 per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid the cycle after rd_en |
| irq_level | output | 1 | Level presented on the interrupt pin |
| irq_oe | output | 1 | Output enable of the interrupt pin |

## Verification
The assertions assume that the condition lines and the register strobes are synchronous to `clk` and change only between edges. The latched-status property also assumes that a status bit can drop only through a read of its own group. The stimulus changes lines and strobes only on falling edges. It never issues a read while reset is active, and it changes one line at a time, except in the test that deliberately places an event and a read on the same edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    KIND_MASK = 2'd0,
    KIND_EDGE = 2'd1,
    KIND_LIVE = 2'd2,
    KIND_PEND = 2'd3
  } reg_kind_e;

  localparam logic [1:0] GKIND_PINCFG = 2'd0;
  localparam logic [1:0] GKIND_CHIND  = 2'd1;

  typedef enum logic [1:0] {
    PIN_OD_A   = 2'b00,
    PIN_PP_LOW = 2'b01,
    PIN_OD_B   = 2'b10,
    PIN_PP_HI  = 2'b11
  } pin_mode_e;

  localparam logic [1:0] PIN_MODE_RST = 2'b00;

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] live,
  input  logic [N-1:0] any_change,
  output logic [N-1:0] evt
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= live;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      always_comb begin
        if (any_change[i]) evt[i] = live[i] ^ prev_q[i];
        else               evt[i] = live[i] & ~prev_q[i];
      end
    end
  endgenerate
endmodule

// File: rtl/irqc_chan.sv
module irqc_chan #(
  parameter int DATA_W = 8,
  parameter int GROUPS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DATA_W*GROUPS-1:0]   live,
  input  logic [GROUPS-1:0]          wr_mask,
  input  logic [GROUPS-1:0]          wr_edge,
  input  logic [GROUPS-1:0]          clr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W*GROUPS-1:0]   mask_q,
  output logic [DATA_W*GROUPS-1:0]   edge_q,
  output logic [DATA_W*GROUPS-1:0]   pend_q,
  output logic                       req
);
  localparam int NSRC = DATA_W * GROUPS;

  logic [NSRC-1:0] evt;

  irqc_edge #(.N(NSRC)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .live       (live),
    .any_change (edge_q),
    .evt        (evt)
  );

  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mask_q[g*DATA_W +: DATA_W] <= '1;
          edge_q[g*DATA_W +: DATA_W] <= '0;
          pend_q[g*DATA_W +: DATA_W] <= '0;
        end else begin
          if (wr_mask[g]) mask_q[g*DATA_W +: DATA_W] <= wr_data;
          if (wr_edge[g]) edge_q[g*DATA_W +: DATA_W] <= wr_data;
          pend_q[g*DATA_W +: DATA_W] <= evt[g*DATA_W +: DATA_W] |
            (pend_q[g*DATA_W +: DATA_W] & ~{DATA_W{clr[g]}});
        end
      end
    end
  endgenerate

  assign req = |(pend_q & ~mask_q);
endmodule

// File: rtl/irqc_pin.sv
module irqc_pin
  import irqc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       active,
  output logic       level,
  output logic       oe
);
  always_comb begin
    unique case (pin_mode_e'(mode))
      PIN_PP_LOW: begin oe = 1'b1;   level = ~active; end
      PIN_PP_HI:  begin oe = 1'b1;   level = active;  end
      default:    begin oe = active; level = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int GROUPS = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int ADDR_W = CH_W + 3 + GRP_W,
  localparam int NSRC   = DATA_W * GROUPS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*NSRC-1:0]   cond_live,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     irq_level,
  output logic                     irq_oe
);
  localparam int NALL = NUM_CH * NSRC;

  logic [GRP_W-1:0] a_grp;
  logic [1:0]       a_kind;
  logic             a_glob;
  logic [CH_W-1:0]  a_ch;

  assign a_grp  = addr[GRP_W-1:0];
  assign a_kind = addr[GRP_W +: 2];
  assign a_glob = addr[GRP_W+2];
  assign a_ch   = addr[ADDR_W-1 -: CH_W];

  logic [NALL-1:0]   mask_all, edge_all, pend_all, clr_all;
  logic [NUM_CH-1:0] chan_req;
  logic [1:0]        pin_mode;
  logic              irq_active;

  genvar c, g;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic [GROUPS-1:0] wr_mask_c, wr_edge_c, clr_c;
      for (g = 0; g < GROUPS; g++) begin : g_dec
        logic hit;
        assign hit = !a_glob && (a_ch == CH_W'(c)) && (a_grp == GRP_W'(g));
        assign wr_mask_c[g] = wr_en && hit && (reg_kind_e'(a_kind) == KIND_MASK);
        assign wr_edge_c[g] = wr_en && hit && (reg_kind_e'(a_kind) == KIND_EDGE);
        assign clr_c[g]     = rd_en && hit && (reg_kind_e'(a_kind) == KIND_PEND);
        assign clr_all[c*NSRC + g*DATA_W +: DATA_W] = {DATA_W{clr_c[g]}};
      end

      irqc_chan #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (cond_live[c*NSRC +: NSRC]),
        .wr_mask (wr_mask_c),
        .wr_edge (wr_edge_c),
        .clr     (clr_c),
        .wr_data (wr_data),
        .mask_q  (mask_all[c*NSRC +: NSRC]),
        .edge_q  (edge_all[c*NSRC +: NSRC]),
        .pend_q  (pend_all[c*NSRC +: NSRC]),
        .req     (chan_req[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) pin_mode <= PIN_MODE_RST;
    else if (wr_en && a_glob && a_kind == GKIND_PINCFG) pin_mode <= wr_data[1:0];
  end

  assign irq_active = |chan_req;

  irqc_pin u_pin (
    .mode   (pin_mode),
    .active (irq_active),
    .level  (irq_level),
    .oe     (irq_oe)
  );

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (a_glob) begin
      if (a_kind == GKIND_PINCFG)      rd_mux[1:0] = pin_mode;
      else if (a_kind == GKIND_CHIND) begin
        for (int i = 0; i < NUM_CH && i < DATA_W; i++) rd_mux[i] = chan_req[i];
      end
    end else begin
      for (int ci = 0; ci < NUM_CH; ci++) begin
        for (int gi = 0; gi < GROUPS; gi++) begin
          if (a_ch == CH_W'(ci) && a_grp == GRP_W'(gi)) begin
            unique case (reg_kind_e'(a_kind))
              KIND_MASK: rd_mux = mask_all[ci*NSRC + gi*DATA_W +: DATA_W];
              KIND_EDGE: rd_mux = edge_all[ci*NSRC + gi*DATA_W +: DATA_W];
              KIND_LIVE: rd_mux = cond_live[ci*NSRC + gi*DATA_W +: DATA_W];
              default:   rd_mux = pend_all[ci*NSRC + gi*DATA_W +: DATA_W];
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NALL   = 64,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        pin_mode,
  input logic              irq_level,
  input logic              irq_oe,
  input logic [NALL-1:0]   cond_live,
  input logic [NALL-1:0]   mask_all,
  input logic [NALL-1:0]   edge_all,
  input logic [NALL-1:0]   pend_all,
  input logic [NALL-1:0]   clr_all
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((&mask_all) && (edge_all == '0) && !irq_oe));

  assert_rise_needs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(pend_all) & pend_all & ~$past(edge_all) & ~$past(cond_live)) == '0));

  assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_all) & ~$past(clr_all)) & ~pend_all) == '0));

  assert_open_drain_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_mode[0] && irq_oe) |-> !irq_level);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind irq_status_ctrl irqc_checker #(.NALL(NALL), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .pin_mode  (pin_mode),
  .irq_level (irq_level),
  .irq_oe    (irq_oe),
  .cond_live (cond_live),
  .mask_all  (mask_all),
  .edge_all  (edge_all),
  .pend_all  (pend_all),
  .clr_all   (clr_all)
);

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 8;
  localparam int GROUPS = 2;
  localparam int NALL   = NUM_CH * DATA_W * GROUPS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NALL-1:0] cond_live = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [5:0]      addr = '0;
  logic [7:0]      wr_data = '0;
  logic [7:0]      rd_data;
  logic            irq_level, irq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rsp_due = 1'b0;

  always #4 clk = ~clk;

  irq_status_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .GROUPS(GROUPS)) dut (
    .clk(clk), .rst_n(rst_n), .cond_live(cond_live), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_level(irq_level), .irq_oe(irq_oe)
  );

  function automatic logic [5:0] ra(int ch, bit glob, int kind, int grp);
    return {ch[1:0], glob, kind[1:0], grp[0]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data becomes valid
  always @(posedge clk) rsp_due <= rd_en;
  always @(negedge clk) begin
    if (rsp_due && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, rd_data, e);
    end
  end

  task automatic wr(logic [5:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] e, string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic setsrc(int idx, logic v);
    cond_live[idx] = v;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin oe", {7'd0, irq_oe}, 8'h00);
    rd(ra(0, 0, 0, 0), 8'hFF, "R1 mask c0g0");
    rd(ra(3, 0, 0, 1), 8'hFF, "R1 mask c3g1");
    rd(ra(1, 0, 1, 0), 8'h00, "R1 edge c1g0");
    rd(ra(0, 1, 0, 0), 8'h00, "R1 pin mode");

    // R2 rising only
    setsrc(3, 1'b1);
    chk("R7 masked no irq", {7'd0, irq_oe}, 8'h00);
    rd(ra(0, 0, 3, 0), 8'h08, "R2 rise latched");
    rd(ra(0, 0, 3, 0), 8'h00, "R4 cleared by read");
    setsrc(3, 1'b0);
    rd(ra(0, 0, 3, 0), 8'h00, "R2 fall ignored");

    // R6 live level
    rd(ra(0, 0, 2, 0), 8'h00, "R6 live low");
    setsrc(5, 1'b1);
    rd(ra(0, 0, 2, 0), 8'h20, "R6 live high");
    rd(ra(0, 0, 3, 0), 8'h20, "R2 second rise");

    // R3 any change
    wr(ra(2, 0, 1, 1), 8'h01);
    rd(ra(2, 0, 1, 1), 8'h01, "R10 edge readback");
    setsrc(40, 1'b1);
    rd(ra(2, 0, 3, 1), 8'h01, "R3 rise");
    setsrc(40, 1'b0);
    rd(ra(2, 0, 3, 1), 8'h01, "R3 fall");
    rd(ra(2, 0, 3, 1), 8'h00, "R3 cleared");

    // R7 / R9 unmasked event
    wr(ra(1, 0, 0, 0), 8'hFE);
    setsrc(16, 1'b1);
    chk("R7 irq oe", {7'd0, irq_oe}, 8'h01);
    chk("R8 od level", {7'd0, irq_level}, 8'h00);
    rd(ra(0, 1, 1, 0), 8'h02, "R9 chan ind c1");

    // R8 modes while active
    wr(ra(0, 1, 0, 0), 8'h01);
    chk("R8 pp low oe", {7'd0, irq_oe}, 8'h01);
    chk("R8 pp low lvl", {7'd0, irq_level}, 8'h00);
    wr(ra(0, 1, 0, 0), 8'h03);
    chk("R8 pp high lvl", {7'd0, irq_level}, 8'h01);
    wr(ra(0, 1, 0, 0), 8'h02);
    chk("R8 od2 oe", {7'd0, irq_oe}, 8'h01);
    chk("R8 od2 lvl", {7'd0, irq_level}, 8'h00);
    rd(ra(1, 0, 3, 0), 8'h01, "R4 c1 pend");
    chk("R7 released oe", {7'd0, irq_oe}, 8'h00);
    wr(ra(0, 1, 0, 0), 8'h03);
    chk("R8 pp high idle", {6'd0, irq_oe, irq_level}, 8'h02);
    wr(ra(0, 1, 0, 0), 8'h01);
    chk("R8 pp low idle", {6'd0, irq_oe, irq_level}, 8'h03);
    wr(ra(0, 1, 0, 0), 8'h00);
    chk("R8 od idle", {7'd0, irq_oe}, 8'h00);

    // R5 event on the read edge
    setsrc(50, 1'b1);
    cond_live[55] = 1'b1;
    rd(ra(3, 0, 3, 0), 8'h04, "R5 old value");
    rd(ra(3, 0, 3, 0), 8'h80, "R5 event kept");

    // R10 ignored writes
    wr(ra(3, 0, 3, 0), 8'hFF);
    rd(ra(3, 0, 3, 0), 8'h00, "R10 pend write ignored");
    wr(ra(3, 0, 2, 0), 8'h00);
    rd(ra(3, 0, 2, 0), 8'h84, "R10 live write ignored");
    wr(ra(0, 1, 1, 0), 8'hFF);
    rd(ra(0, 1, 1, 0), 8'h00, "R10 ind write ignored");
    wr(ra(2, 0, 0, 1), 8'h5A);
    rd(ra(2, 0, 0, 1), 8'h5A, "R10 mask readback");
    repeat (3) @(negedge clk);
    chk("R10 rdata hold", rd_data, 8'h5A);

    // R9 / R7 another channel, then mask it
    wr(ra(3, 0, 0, 1), 8'h7F);
    setsrc(63, 1'b1);
    rd(ra(0, 1, 1, 0), 8'h08, "R9 chan ind c3");
    chk("R7 irq c3", {7'd0, irq_oe}, 8'h01);
    wr(ra(3, 0, 0, 1), 8'hFF);
    chk("R7 masked release", {7'd0, irq_oe}, 8'h00);
    rd(ra(3, 0, 3, 1), 8'h80, "R7 masked still latched");

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule